// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sets the timing of a successive-approximation conversion sequence from the bus clock. After a start trigger it latches a configuration word and runs a fixed startup interval counted in bus cycles. A second startup interval follows, counted in conversion-clock cycles. Each conversion of the sequence then has an optional long-sample interval and a bit-conversion interval. The conversion clock is a one-cycle enable derived from the bus clock by a power-of-two divide ratio.

The analog front end is represented by a stub that masks a word supplied from outside. The word is captured once per conversion. The captured words are summed over a power-of-two averaging count, and the sum is shifted down to give the averaged result. A one-cycle completion pulse marks the bus cycle in which the result becomes valid.

Top module: `adcseq_top`

## Requirements
- R1: During and after a synchronous active-low reset, `phase` is idle (0), `done` is 0, `result` is 0 and `conv_ck_en` is 0.
- R2: A `start` sampled high while idle is accepted. From the next cycle `phase` reads startup (1) for 5 bus cycles. It stays at startup for a further 5 conversion-clock cycles when `div_sel` is 0, and for 3 conversion-clock cycles for any other `div_sel`.
- R3: While `phase` is startup, sample or convert and the bus-cycle part of startup has ended, `conv_ck_en` pulses once every 2^`div_sel` bus cycles. The first pulse comes 2^`div_sel` cycles after the bus-cycle part ends. `conv_ck_en` is 0 at all other times.
- R4: Each conversion first shows sample (2) for a long-sample adder of 20, 12, 6 or 2 conversion-clock cycles for `ls_sel` 0, 1, 2 or 3. This interval is skipped when `ls_en` is 0. It then shows convert (3) for a base time plus a high-speed adder. The base time is 20 cycles when `wide` is 0 and 34 cycles when `wide` is 1. The high-speed adder is 2 cycles when `hs_en` is 1 and 0 otherwise.
- R5: The number of conversions in a sequence is 2^min(`avg_log`, 5). This gives 1 when `avg_log` is 0 and 32 when `avg_log` is 5, 6 or 7.
- R6: `done` rises L edges after the accepting edge, where L = 5 + 2^`div_sel` × (startup clocks + count × (base + long adder + high-speed adder)). With `wide`=0, `div_sel`=0 and no adders, L is 30.
- R7: The stub supplies one word per conversion. It is sampled at the last conversion-clock pulse of the convert interval. When `wide` is 0 only bits 9:0 of `adc_word` are used and the upper bits read as 0. When `wide` is 1 all 16 bits are used.
- R8: `result` equals the sum of the sampled words shifted right by min(`avg_log`, 5). It is updated only in the `done` cycle and held until the next one.
- R9: `done` is high for exactly one bus cycle. In that same cycle `phase` is already idle.
- R10: A `start` while a sequence runs is ignored and does not change the phase sequence or its timing.
- R11: The configuration inputs are latched at acceptance. Changes to them during a sequence have no effect on its timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Sequence trigger |
| wide | input | 1 | 0: 10-bit single-ended, 1: 16-bit differential |
| div_sel | input | 2 | Conversion clock divide ratio is 2^div_sel |
| ls_en | input | 1 | Long-sample adder enable |
| ls_sel | input | 2 | Long-sample adder select, 0 is longest |
| hs_en | input | 1 | High-speed adder enable |
| avg_log | input | 3 | log2 of the averaging count, clamped at 5 |
| adc_word | input | 16 | Stub conversion word |
| conv_ck_en | output | 1 | Conversion clock enable pulse |
| phase | output | 2 | 0 idle, 1 startup, 2 sample, 3 convert |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Averaged result |

## Verification
A bench model turns each accepted trigger into a list of expected values, one entry per bus cycle: the phase, the conversion-clock pulse and a capture mark. Each later cycle pops one entry and compares it with the outputs at the falling edge. The `done` pulse and the new `result` are expected one cycle after the entry with the final capture mark, which is L edges after the accepting edge. The bench also checks that count directly against the closed-form latency of R6. The stimulus word changes every cycle, so a capture taken one cycle early or late produces a different sum.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    // Externally visible phase code
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_START  = 2'd1,
        PH_SAMPLE = 2'd2,
        PH_CONV   = 2'd3
    } phase_e;

    // Latched sequence configuration
    typedef struct packed {
        logic       wide;
        logic [1:0] div_sel;
        logic       ls_en;
        logic [1:0] ls_sel;
        logic       hs_en;
        logic [2:0] avg_log;
    } seq_cfg_t;

endpackage

// File: rtl/adcseq_clkdiv.sv
// Conversion clock enable generator.
// Produces a one-cycle tick every 2^div_sel bus cycles while run is high.
// Assumes: the counter is held at zero while run is low, so the first tick
// after run rises is exactly 2^div_sel cycles later.
module adcseq_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Terminal count 2^div_sel - 1 as a thermometer of ones
    always_comb begin
        lim = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(div_sel)) lim[i] = 1'b1;
        end
    end

    assign tick = run && (cnt == lim);

    // Divider counter, cleared when stopped or at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adcseq_timer.sv
// Phase sequencer for one triggered conversion sequence.
// Runs a bus-cycle startup, a conversion-clock startup, then per conversion
// an optional long-sample interval and a convert interval, repeated over the
// averaging count. Flags the capture point of each conversion and the final one.
// Assumes: tick comes from a divider that runs only while ck_run is high.
module adcseq_timer
    import adcseq_pkg::*;
#(
    parameter int STARTUP_BUS = 5,
    parameter int SU_CK_DIV1  = 5,
    parameter int SU_CK_DIVN  = 3,
    parameter int BASE_NARROW = 20,
    parameter int BASE_WIDE   = 34,
    parameter int HS_ADD      = 2,
    parameter int LS_ADD0     = 20,
    parameter int LS_ADD1     = 12,
    parameter int LS_ADD2     = 6,
    parameter int LS_ADD3     = 2,
    parameter int AVG_LOG_MAX = 5,
    parameter int PC_W        = 8,
    parameter int SH_W        = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  seq_cfg_t        cfg_in,
    input  logic            tick,
    output seq_cfg_t        cfg_q,
    output phase_e          phase,
    output logic            ck_run,
    output logic            cap,
    output logic            fin,
    output logic [SH_W-1:0] avg_shift
);
    localparam int NC_W = AVG_LOG_MAX + 1;

    typedef enum logic [2:0] {
        T_IDLE, T_BUSW, T_CKUP, T_SMP, T_CNV
    } tstate_e;

    tstate_e          st;
    logic [PC_W-1:0]  pc;
    logic [NC_W-1:0]  nconv;
    logic [PC_W-1:0]  su_len;
    logic [PC_W-1:0]  ls_len;
    logic [PC_W-1:0]  cv_len;
    logic [NC_W-1:0]  last_idx;
    logic             last_conv;
    logic             cv_end;

    // Startup clock count depends on whether the divider bypasses
    always_comb su_len = (cfg_q.div_sel == '0) ? PC_W'(SU_CK_DIV1) : PC_W'(SU_CK_DIVN);

    // Long-sample adder lookup
    always_comb begin
        unique case (cfg_q.ls_sel)
            2'd0:    ls_len = PC_W'(LS_ADD0);
            2'd1:    ls_len = PC_W'(LS_ADD1);
            2'd2:    ls_len = PC_W'(LS_ADD2);
            default: ls_len = PC_W'(LS_ADD3);
        endcase
        if (!cfg_q.ls_en) ls_len = '0;
    end

    // Convert interval: base time plus high-speed adder
    always_comb cv_len = (cfg_q.wide ? PC_W'(BASE_WIDE) : PC_W'(BASE_NARROW))
                       + (cfg_q.hs_en ? PC_W'(HS_ADD) : '0);

    // Clamped averaging shift
    always_comb avg_shift = (int'(cfg_q.avg_log) > AVG_LOG_MAX)
                          ? SH_W'(AVG_LOG_MAX) : SH_W'(cfg_q.avg_log);

    // Index of the last conversion, 2^shift - 1
    always_comb begin
        last_idx = '0;
        for (int i = 0; i < NC_W; i++) begin
            if (i < int'(avg_shift)) last_idx[i] = 1'b1;
        end
    end

    assign last_conv = (nconv == last_idx);
    assign cv_end    = (st == T_CNV) && tick && (pc == cv_len - 1'b1);
    assign cap       = cv_end;
    assign fin       = cv_end && last_conv;
    assign ck_run    = (st == T_CKUP) || (st == T_SMP) || (st == T_CNV);

    // External phase code from internal state
    always_comb begin
        unique case (st)
            T_BUSW, T_CKUP: phase = PH_START;
            T_SMP:          phase = PH_SAMPLE;
            T_CNV:          phase = PH_CONV;
            default:        phase = PH_IDLE;
        endcase
    end

    // Sequence state, interval counter and conversion counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= T_IDLE;
            pc    <= '0;
            nconv <= '0;
            cfg_q <= '0;
        end else begin
            unique case (st)
                T_IDLE: begin
                    if (start) begin
                        cfg_q <= cfg_in;
                        st    <= T_BUSW;
                        pc    <= '0;
                        nconv <= '0;
                    end
                end
                T_BUSW: begin
                    if (pc == PC_W'(STARTUP_BUS - 1)) begin
                        pc <= '0;
                        st <= T_CKUP;
                    end else begin
                        pc <= pc + 1'b1;
                    end
                end
                T_CKUP: begin
                    if (tick) begin
                        if (pc == su_len - 1'b1) begin
                            pc <= '0;
                            st <= (ls_len != '0) ? T_SMP : T_CNV;
                        end else begin
                            pc <= pc + 1'b1;
                        end
                    end
                end
                T_SMP: begin
                    if (tick) begin
                        if (pc == ls_len - 1'b1) begin
                            pc <= '0;
                            st <= T_CNV;
                        end else begin
                            pc <= pc + 1'b1;
                        end
                    end
                end
                T_CNV: begin
                    if (tick) begin
                        if (pc == cv_len - 1'b1) begin
                            pc <= '0;
                            if (last_conv) begin
                                st <= T_IDLE;
                            end else begin
                                nconv <= nconv + 1'b1;
                                st    <= (ls_len != '0) ? T_SMP : T_CNV;
                            end
                        end else begin
                            pc <= pc + 1'b1;
                        end
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adcseq_stub.sv
// Analog stand-in: returns the externally supplied word, masked to the
// active resolution.
// Assumes: NARROW_W is smaller than DATA_W.
module adcseq_stub #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 10
) (
    input  logic              wide,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] word
);
    localparam int PAD_W = DATA_W - NARROW_W;

    // Resolution mask
    always_comb word = wide ? raw : {{PAD_W{1'b0}}, raw[NARROW_W-1:0]};
endmodule

// File: rtl/adcseq_avg.sv
// Averaging accumulator. Sums captured words and on the final capture
// presents the sum shifted by the averaging log with a one-cycle done.
// Assumes: every sequence ends with a fin strobe, so the sum restarts at 0.
module adcseq_avg #(
    parameter int DATA_W      = 16,
    parameter int AVG_LOG_MAX = 5,
    parameter int SH_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic              fin,
    input  logic [DATA_W-1:0] word,
    input  logic [SH_W-1:0]   shift,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int ACC_W = DATA_W + AVG_LOG_MAX;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum_next;

    always_comb sum_next = acc + ACC_W'(word);

    // Accumulate, and publish the averaged value on the final capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (cap) begin
                if (fin) begin
                    acc    <= '0;
                    result <= DATA_W'(sum_next >> shift);
                    done   <= 1'b1;
                end else begin
                    acc <= sum_next;
                end
            end
        end
    end
endmodule

// File: rtl/adcseq_top.sv
// Conversion timing sequencer top level.
// Joins the phase sequencer, the conversion clock divider, the analog stub
// and the averaging accumulator.
// Assumes: adc_word is valid at every conversion-clock pulse.
module adcseq_top
    import adcseq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int NARROW_W    = 10,
    parameter int DIV_W       = 2,
    parameter int AVG_LOG_MAX = 5,
    parameter int SH_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              ls_en,
    input  logic [1:0]        ls_sel,
    input  logic              hs_en,
    input  logic [SH_W-1:0]   avg_log,
    input  logic [DATA_W-1:0] adc_word,
    output logic              conv_ck_en,
    output logic [1:0]        phase,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    seq_cfg_t          cfg_in;
    seq_cfg_t          cfg_q;
    phase_e            ph;
    logic              ck_run;
    logic              tick;
    logic              cap;
    logic              fin;
    logic [SH_W-1:0]   avg_shift;
    logic [DATA_W-1:0] word;

    // Pack configuration pins
    always_comb begin
        cfg_in.wide    = wide;
        cfg_in.div_sel = div_sel;
        cfg_in.ls_en   = ls_en;
        cfg_in.ls_sel  = ls_sel;
        cfg_in.hs_en   = hs_en;
        cfg_in.avg_log = avg_log;
    end

    adcseq_timer #(
        .AVG_LOG_MAX (AVG_LOG_MAX),
        .SH_W        (SH_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_in    (cfg_in),
        .tick      (tick),
        .cfg_q     (cfg_q),
        .phase     (ph),
        .ck_run    (ck_run),
        .cap       (cap),
        .fin       (fin),
        .avg_shift (avg_shift)
    );

    adcseq_clkdiv #(
        .SEL_W (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ck_run),
        .div_sel (cfg_q.div_sel),
        .tick    (tick)
    );

    adcseq_stub #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_stub (
        .wide (cfg_q.wide),
        .raw  (adc_word),
        .word (word)
    );

    adcseq_avg #(
        .DATA_W      (DATA_W),
        .AVG_LOG_MAX (AVG_LOG_MAX),
        .SH_W        (SH_W)
    ) u_avg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .fin    (fin),
        .word   (word),
        .shift  (avg_shift),
        .done   (done),
        .result (result)
    );

    assign conv_ck_en = tick;
    assign phase      = ph;
endmodule

// File: rtl/adcseq_chk.sv
// Temporal checks on the sequencer ports, attached by bind.
module adcseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        conv_ck_en,
    input logic [1:0]  phase,
    input logic        done,
    input logic [15:0] result
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == 2'd3) && $past(conv_ck_en) && (phase == 2'd0));

    // R3
    ck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ck_en |-> (phase != 2'd0));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) && start |=> (phase == 2'd1));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3) && start && !conv_ck_en |=> (phase == 2'd3));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable(result)));
endmodule

bind adcseq_top adcseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .conv_ck_en (conv_ck_en),
    .phase      (phase),
    .done       (done),
    .result     (result)
);

// File: tb/tb_adcseq_top.sv
module tb_adcseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [1:0]  div_sel = '0;
    logic        ls_en = 1'b0;
    logic [1:0]  ls_sel = '0;
    logic        hs_en = 1'b0;
    logic [2:0]  avg_log = '0;
    logic [15:0] adc_word = '0;
    logic        conv_ck_en;
    logic [1:0]  phase;
    logic        done;
    logic [15:0] result;

    always #5 clk = ~clk;

    adcseq_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide),
        .div_sel(div_sel), .ls_en(ls_en), .ls_sel(ls_sel), .hs_en(hs_en),
        .avg_log(avg_log), .adc_word(adc_word), .conv_ck_en(conv_ck_en),
        .phase(phase), .done(done), .result(result)
    );

    typedef struct packed {
        logic [1:0] ph;
        logic       ck;
        logic       cap;
        logic       fin;
    } ent_t;

    typedef struct packed {
        logic       w;
        logic [1:0] dv;
        logic       le;
        logic [1:0] ls;
        logic       hs;
        logic [2:0] av;
    } bcfg_t;

    ent_t    q[$];
    bcfg_t   drv;
    bcfg_t   mcfg;
    int      n_chk = 0;
    int      n_fail = 0;
    int      cyc = 0;
    int      acc_cyc = 0;
    int      exp_lat = 0;
    bit      pend_done = 1'b0;
    longint  sum = 0;
    int      exp_res = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    function automatic int ls_cyc(input bcfg_t c);
        if (!c.le) return 0;
        case (c.ls)
            2'd0: return 20;
            2'd1: return 12;
            2'd2: return 6;
            default: return 2;
        endcase
    endfunction

    function automatic int cnt_of(input bcfg_t c);
        return 1 << ((c.av > 3'd5) ? 5 : int'(c.av));
    endfunction

    // Expected per-cycle list for one accepted sequence
    task automatic build(input bcfg_t c);
        int ratio = 1 << c.dv;
        int su = (c.dv == 2'd0) ? 5 : 3;
        int base = (c.w ? 34 : 20) + (c.hs ? 2 : 0);
        int ls = ls_cyc(c);
        int n = cnt_of(c);
        for (int i = 0; i < 5; i++) q.push_back('{2'd1, 1'b0, 1'b0, 1'b0});
        for (int k = 0; k < su; k++)
            for (int r = 0; r < ratio; r++) q.push_back('{2'd1, r == ratio-1, 1'b0, 1'b0});
        for (int v = 0; v < n; v++) begin
            for (int k = 0; k < ls; k++)
                for (int r = 0; r < ratio; r++) q.push_back('{2'd2, r == ratio-1, 1'b0, 1'b0});
            for (int k = 0; k < base; k++)
                for (int r = 0; r < ratio; r++) begin
                    logic cp = (k == base-1) && (r == ratio-1);
                    q.push_back('{2'd3, r == ratio-1, cp, cp && (v == n-1)});
                end
        end
        exp_lat = 5 + ratio * (su + n * (base + ls));
    endtask

    // One bus cycle: compare outputs, drive inputs, advance the model
    task automatic step(input logic s);
        ent_t e = '0;
        bit   bsy = 1'b0;
        bit   edone;
        @(negedge clk);
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected below 190000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
        edone = pend_done;
        pend_done = 1'b0;
        if (q.size() > 0) begin
            e = q.pop_front();
            bsy = 1'b1;
        end
        chk("R4", "phase", int'(phase), bsy ? int'(e.ph) : 0);
        chk("R3", "conv_ck_en", int'(conv_ck_en), bsy ? int'(e.ck) : 0);
        chk("R9", "done", int'(done), int'(edone));
        chk("R8", "result", int'(result), exp_res);
        if (edone) chk("R6", "latency", cyc - acc_cyc - 1, exp_lat);
        start    = s;
        adc_word = 16'(cyc * 40503 + 4660);
        wide = drv.w; div_sel = drv.dv; ls_en = drv.le; ls_sel = drv.ls;
        hs_en = drv.hs; avg_log = drv.av;
        if (bsy && e.cap) begin
            // R7: narrow mode keeps bits 9:0 only
            sum += mcfg.w ? longint'(adc_word) : longint'(adc_word & 16'h03ff);
            if (e.fin) begin
                exp_res = int'(sum >> ((mcfg.av > 3'd5) ? 5 : int'(mcfg.av)));
                sum = 0;
                pend_done = 1'b1;
            end
        end
        if (!bsy && s) begin
            mcfg = drv;
            acc_cyc = cyc;
            build(drv);
        end
    endtask

    // Run one sequence; optionally disturb start and config while busy
    task automatic run(input bcfg_t c, input bit disturb, input bcfg_t alt);
        drv = c;
        step(1'b1);
        if (disturb) begin
            drv = alt;
            for (int i = 0; i < 40; i++) step(1'b1);  // R10 R11
            drv = c;
        end
        while (q.size() > 0 || pend_done) step(1'b0);
        step(1'b0);
    endtask

    initial begin
        bcfg_t none = '0;
        drv = '0;
        mcfg = '0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1", "reset phase", int'(phase), 0);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset result", int'(result), 0);
        chk("R1", "reset conv_ck_en", int'(conv_ck_en), 0);
        rst_n = 1'b1;
        step(1'b0);
        // R6: narrow, divide-by-1, no adders, single conversion -> 30
        run('{1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 3'd0}, 1'b0, none);
        chk("R6", "example latency", exp_lat, 30);
        // R2 R4 R5: wide, divide-by-8, longest sample, 32 conversions
        run('{1'b1, 2'd3, 1'b1, 2'd0, 1'b0, 3'd5}, 1'b0, none);
        // R4: divide-by-2, ls_sel 2, high speed, 4 conversions
        run('{1'b1, 2'd1, 1'b1, 2'd2, 1'b1, 3'd2}, 1'b0, none);
        // R7: narrow word masking with ls_sel 3 and divide-by-4
        run('{1'b0, 2'd2, 1'b1, 2'd3, 1'b0, 3'd1}, 1'b0, none);
        // R5: avg_log 7 clamps to 32 conversions, ls_sel 1
        run('{1'b0, 2'd0, 1'b1, 2'd1, 1'b1, 3'd7}, 1'b0, none);
        // R10 R11: retriggers and config changes while busy
        run('{1'b0, 2'd1, 1'b0, 2'd0, 1'b0, 3'd3},
            1'b1, '{1'b1, 2'd3, 1'b1, 2'd0, 1'b1, 3'd5});
        // R2: back-to-back start right after completion
        run('{1'b1, 2'd0, 1'b0, 2'd0, 1'b1, 3'd0}, 1'b0, none);
        repeat (4) step(1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule